// File: doc/BRIEF.md
# Two-Bit Saturating Branch Predictor

This block holds a small table of 2-bit saturating counters that predict the direction of conditional branches. A core presents the address of a conditional branch together with a resolve strobe and the actual direction. The block returns, in the same cycle, the direction the table predicted for that address. It also returns a flag that marks a wrong prediction, the stall cycles that a wrong prediction costs, and a jump event for hazard logic further down the pipe.

The counter for an address is picked by masking the address to the table span and then dropping its lowest bit, because instructions are aligned on 16-bit boundaries. A counter with its upper bit set predicts taken. Each resolved branch moves its counter one step toward the actual outcome, and the counter stops at 0 and at 3. Every counter starts out strongly not taken.

Top module: `bp_sat_predictor`

## Requirements
- R1: The entry used is (pc & (SPAN-1)) >> 1. Address bit 0 has no effect, and addresses that differ only in bits at or above log2(SPAN) share one entry. With SPAN=32 the entry is pc[4:1].
- R2: pred_taken_o is 1 exactly when bit 1 of the selected counter is set (counter value 2 or 3). It is combinational from br_pc_i.
- R3: When br_valid_i is 1 and pred_taken_o differs from br_taken_i, mispredict_o is 1 and penalty_o equals PENALTY (default 2). In every other case mispredict_o is 0 and penalty_o is 0.
- R4: A resolve with br_taken_i=1 raises the selected counter by one at the clock edge, and a counter already at 3 stays at 3.
- R5: A resolve with br_taken_i=0 lowers the selected counter by one at the clock edge, and a counter already at 0 stays at 0.
- R6: jump_o is 1 exactly when br_valid_i and br_taken_i are both 1.
- R7: After reset every counter is 0, so every address predicts not taken.
- R8: While br_valid_i is 0, no counter changes, whatever br_pc_i and br_taken_i do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_valid_i | input | 1 | A conditional branch resolves this cycle |
| br_pc_i | input | PC_W | Address of the branch |
| br_taken_i | input | 1 | Actual direction of the branch |
| pred_taken_o | output | 1 | Predicted direction for br_pc_i |
| mispredict_o | output | 1 | The prediction was wrong for the resolving branch |
| penalty_o | output | PEN_W | Stall cycles caused by this resolve |
| jump_o | output | 1 | Taken branch event for hazard tracking |

## Verification
The bench builds the block with its defaults: a 32-byte table span, which gives 16 counters, a 32-bit address and a 2-cycle penalty. With only 16 entries, the bench can sweep every counter after reset, walk a single counter through both saturation points, and show aliasing with an address just 32 bytes away. A long run of pseudo-random addresses and directions then mixes updates across many entries, checked against a reference table of counters.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'd0;
  localparam ctr_t CTR_MAX   = 2'd3;

  function automatic ctr_t ctr_step(ctr_t c, logic taken);
    ctr_t n;
    n = c;
    if (taken && c != CTR_MAX) n = c + 2'd1;
    else if (!taken && c != CTR_RESET) n = c - 2'd1;
    return n;
  endfunction

  function automatic logic ctr_dir(ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/bp_index.sv
module bp_index #(
  parameter int PC_W  = 32,
  parameter int SPAN  = 32,
  localparam int IDX_HI = $clog2(SPAN) - 1,
  localparam int IDX_W  = IDX_HI
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o
);
  // bit 0 dropped: 16-bit aligned instructions
  assign idx_o = pc_i[IDX_HI:1];

  logic unused_pc;
  assign unused_pc = ^pc_i;
endmodule

// File: rtl/bp_counter_bank.sv
module bp_counter_bank
  import bp_pkg::*;
#(
  parameter int IDX_W = 4,
  localparam int ENTRIES = 2 ** IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_taken_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_ctr_o
);
  ctr_t ctr_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ctr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctr_q[g] <= CTR_RESET;
      end else if (upd_en_i && upd_idx_i == IDX_W'(g)) begin
        ctr_q[g] <= ctr_step(ctr_q[g], upd_taken_i);
      end
    end
  end

  assign rd_ctr_o = ctr_q[rd_idx_i];
endmodule

// File: rtl/bp_resolve.sv
module bp_resolve #(
  parameter int PENALTY = 2,
  parameter int PEN_W   = 2
) (
  input  logic             valid_i,
  input  logic             pred_i,
  input  logic             taken_i,
  output logic             mispredict_o,
  output logic [PEN_W-1:0] penalty_o,
  output logic             jump_o
);
  assign mispredict_o = valid_i && (pred_i != taken_i);
  assign penalty_o    = mispredict_o ? PEN_W'(PENALTY) : '0;
  assign jump_o       = valid_i && taken_i;
endmodule

// File: rtl/bp_sat_predictor.sv
module bp_sat_predictor
  import bp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int SPAN    = 32,
  parameter int PENALTY = 2,
  localparam int IDX_W  = $clog2(SPAN) - 1,
  localparam int PEN_W  = $clog2(PENALTY + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             br_valid_i,
  input  logic [PC_W-1:0]  br_pc_i,
  input  logic             br_taken_i,
  output logic             pred_taken_o,
  output logic             mispredict_o,
  output logic [PEN_W-1:0] penalty_o,
  output logic             jump_o
);
  logic [IDX_W-1:0] idx;
  ctr_t             ctr;

  bp_index #(.PC_W(PC_W), .SPAN(SPAN)) u_index (
    .pc_i  (br_pc_i),
    .idx_o (idx)
  );

  bp_counter_bank #(.IDX_W(IDX_W)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_en_i    (br_valid_i),
    .upd_idx_i   (idx),
    .upd_taken_i (br_taken_i),
    .rd_idx_i    (idx),
    .rd_ctr_o    (ctr)
  );

  assign pred_taken_o = ctr_dir(ctr);

  bp_resolve #(.PENALTY(PENALTY), .PEN_W(PEN_W)) u_resolve (
    .valid_i      (br_valid_i),
    .pred_i       (pred_taken_o),
    .taken_i      (br_taken_i),
    .mispredict_o (mispredict_o),
    .penalty_o    (penalty_o),
    .jump_o       (jump_o)
  );
endmodule

// File: rtl/bp_sat_predictor_chk.sv
module bp_sat_predictor_chk #(
  parameter int PC_W    = 32,
  parameter int PENALTY = 2,
  parameter int PEN_W   = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             br_valid_i,
  input logic [PC_W-1:0]  br_pc_i,
  input logic             br_taken_i,
  input logic             pred_taken_o,
  input logic             mispredict_o,
  input logic [PEN_W-1:0] penalty_o,
  input logic             jump_o
);
  p_penalty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && pred_taken_o != br_taken_i) |-> (mispredict_o && penalty_o == PEN_W'(PENALTY)));

  p_no_penalty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(br_valid_i && pred_taken_o != br_taken_i) |-> (!mispredict_o && penalty_o == '0));

  // a counter predicting taken stays taken after another taken resolve
  p_taken_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && br_taken_i && pred_taken_o) |=>
      (br_pc_i != $past(br_pc_i)) || pred_taken_o);

  p_nt_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && !br_taken_i && !pred_taken_o) |=>
      (br_pc_i != $past(br_pc_i)) || !pred_taken_o);

  p_jump_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o == (br_valid_i && br_taken_i));

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_valid_i |=> (br_pc_i != $past(br_pc_i)) || $stable(pred_taken_o));
endmodule

bind bp_sat_predictor bp_sat_predictor_chk #(
  .PC_W(PC_W), .PENALTY(PENALTY), .PEN_W(PEN_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .br_valid_i   (br_valid_i),
  .br_pc_i      (br_pc_i),
  .br_taken_i   (br_taken_i),
  .pred_taken_o (pred_taken_o),
  .mispredict_o (mispredict_o),
  .penalty_o    (penalty_o),
  .jump_o       (jump_o)
);

// File: tb/bp_sat_predictor_bench.sv
`timescale 1ns/1ps
module bp_sat_predictor_bench;
  localparam int PC_W    = 32;
  localparam int SPAN    = 32;
  localparam int PENALTY = 2;
  localparam int PEN_W   = $clog2(PENALTY + 1);
  localparam int NENT    = SPAN / 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid = 1'b0;
  logic [PC_W-1:0]  pc = '0;
  logic             taken = 1'b0;
  logic             pred, mis, jmp;
  logic [PEN_W-1:0] pen;

  int n_checks = 0;
  int n_fail   = 0;
  int model [NENT];

  always #10 clk = ~clk;

  bp_sat_predictor #(.PC_W(PC_W), .SPAN(SPAN), .PENALTY(PENALTY)) u_bp_sat_predictor (
    .clk_i(clk), .rst_ni(rst_n), .br_valid_i(valid), .br_pc_i(pc), .br_taken_i(taken),
    .pred_taken_o(pred), .mispredict_o(mis), .penalty_o(pen), .jump_o(jmp)
  );

  function automatic int m_idx(logic [PC_W-1:0] a);
    return int'((a & PC_W'(SPAN - 1)) >> 1);
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (pc=%h)", req, act, exp, pc);
    end
  endtask

  // drive at negedge, sample mid-low phase, model update at posedge
  task automatic resolve(logic [PC_W-1:0] a, logic t);
    int e_pred;
    @(negedge clk);
    valid = 1'b1; pc = a; taken = t;
    #5;
    e_pred = (model[m_idx(a)] >= 2) ? 1 : 0;
    check("R2 prediction", int'(pred), e_pred);
    check("R3 mispredict", int'(mis), (e_pred != int'(t)) ? 1 : 0);
    check("R3 penalty", int'(pen), (e_pred != int'(t)) ? PENALTY : 0);
    check("R6 jump", int'(jmp), int'(t));
    @(posedge clk);
    if (t && model[m_idx(a)] < 3) model[m_idx(a)]++;
    else if (!t && model[m_idx(a)] > 0) model[m_idx(a)]--;
  endtask

  task automatic peek(logic [PC_W-1:0] a, int exp, string req);
    @(negedge clk);
    valid = 1'b0; pc = a; taken = 1'b1;
    #5;
    check(req, int'(pred), exp);
    check("R6 no jump when idle", int'(jmp), 0);
    check("R3 no penalty when idle", int'(pen), 0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NENT; i++) peek(PC_W'(2 * i), 0, "R7 reset not taken");
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 5; i++) resolve(32'h40, 1'b1);   // R4 climbs, holds at 3
    resolve(32'h40, 1'b0);                                // 3->2 still taken
    peek(32'h40, 1, "R4 saturate at 3");
    for (int i = 0; i < 5; i++) resolve(32'h40, 1'b0);   // R5 falls, holds at 0
    resolve(32'h40, 1'b1);                                // 0->1 still not taken
    peek(32'h40, 0, "R5 saturate at 0");
  endtask

  task automatic t_index();
    resolve(32'h6, 1'b1);
    resolve(32'h6, 1'b1);
    peek(32'h7,  1, "R1 bit0 ignored");
    peek(32'h26, 1, "R1 alias above span");
    peek(32'h4,  0, "R1 neighbour entry untouched");
  endtask

  task automatic t_idle();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      valid = 1'b0; pc = 32'h8; taken = 1'b1;
    end
    peek(32'h8, 0, "R8 no update without valid");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      valid = 1'b0; pc = 32'h6; taken = 1'b0;
    end
    peek(32'h6, 1, "R8 no decrement without valid");
  endtask

  task automatic t_mixed();
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      resolve({24'h0, lfsr[7:0]}, lfsr[9] | lfsr[11]);
    end
  endtask

  initial begin
    #(200000 * 20);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NENT; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_saturate();
    t_index();
    t_idle();
    t_mixed();
    @(negedge clk);
    valid = 1'b0;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule